// File: doc/BRIEF.md
# Dual-Clock Petri-Net Subnet Controller

This block is a logic controller derived from a Petri net that has been cut into two concurrent state-machine subnets. Each subnet is a lane of its own. A lane has a combinational next-place circuit, a register that holds the binary code of the marked place, and an output decoder that turns that code into the lane's output word. Each lane runs on its own clock, and the two clocks need not be related.

The places of a lane form a ring. Place k is left through transition k, which is guarded by input bit k and leads to place k+1. One place on the ring, the join place, is the input place of a transition that belongs to both lanes. That shared transition needs the lane's own guard and also agreement from the partner lane.

Agreement is carried by a small round counter in each lane. The counter steps once when the lane arrives at the join place and once when it leaves it. The counter crosses to the other clock domain in Gray code through a two-flop synchronizer. A lane therefore keeps announcing that it has taken the shared transition until the partner has caught up. A fast lane can then neither take the join alone nor take it twice.

Top module: `pnd_dual_ctrl`

## Requirements
- R1: A low `rst_n` forces both lanes at once, without a clock edge, to place code 0 with round count 0. Both output words become the place-0 word, which is 00 for the default maps. Each lane leaves reset on an edge of its own clock after a two-flop release.
- R2: Place k of a lane has binary code k, `$clog2(NPLACE)` bits wide. Each lane drives only its own output vector, which is the map word of its current place. Lane A maps places 0..3 to 00, 01, 11, 10. Lane B maps them to 00, 10, 11, 01.
- R3: At a place k other than the join place, a lane moves to place k+1 on a clock edge where guard bit k is high. Place NPLACE-1 wraps to place 0.
- R4: A lane whose guard bit for the current place is low keeps its place. Guard bits of the other places have no effect.
- R5: The shared transition out of place `JOIN` (default 2) is taken by a lane only when its guard bit `JOIN` is high and the partner is at its join place in the same round. It is also taken when the partner has already taken the shared transition in that round. With its own guard low, a lane waits even when the partner is ready.
- R6: A lane at the join place whose partner has not yet reached the join place in the same round stays there for as long as that lasts.
- R7: A lane that arrives late at the join place proceeds once its guard rises, even though the partner has already left the join place.
- R8: A lane that laps the ring and is back at the join place before the partner has taken the previous shared transition waits there. It never takes the shared transition twice while the partner takes it once.
- R9: Each lane changes place only on edges of its own clock. While one clock is stopped, that lane stays frozen and the other lane keeps moving.
- R10: The round count of a lane is a 3-bit Gray code that changes by at most one bit per local clock cycle. Its low binary bit is 1 exactly while the lane sits at the join place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Local clock of lane A |
| clk_b | input | 1 | Local clock of lane B, unrelated to clk_a |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| x_a | input | NPLACE | Guard bits of lane A, bit k guards the exit from place k |
| x_b | input | NPLACE | Guard bits of lane B, bit k guards the exit from place k |
| y_a | output | NOUT | Output word of lane A, decoded from its place |
| y_b | output | NOUT | Output word of lane B, decoded from its place |

## Verification
The bench uses the defaults NPLACE=4, JOIN=2 and NOUT=2. The two maps give a distinct word to every place, so the marked place of each lane can be read straight off the outputs. A pseudo-random sequence picks which lane to step next, over enough steps for the 3-bit round counters to wrap several times. This covers every arrival order at the join: both waiting, one leaving before the other arrives, and one lane lapping the ring ahead of its partner. The lanes are clocked at 4 ns and 6.6 ns. One phase stops lane B's clock entirely to show that the two domains are independent.

// File: rtl/pnd_pkg.sv
`timescale 1ns/1ps
package pnd_pkg;
  // Round counter width: lanes drift at most two steps apart, so 3 bits keep
  // the signed difference unambiguous.
  localparam int PHW = 3;

  function automatic logic [PHW-1:0] to_gray(input logic [PHW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PHW-1:0] from_gray(input logic [PHW-1:0] g);
    logic [PHW-1:0] b;
    b[PHW-1] = g[PHW-1];
    for (int i = PHW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Waiting lane at round count 'mine' (odd). Partner equal: also waiting.
  // Partner +1: it left the join. Partner +2: it left and is waiting again.
  function automatic logic join_allowed(input logic [PHW-1:0] mine,
                                        input logic [PHW-1:0] peer);
    logic [PHW-1:0] diff;
    diff = peer - mine;
    return diff <= PHW'(2);
  endfunction
endpackage

// File: rtl/pnd_rst_sync.sv
`timescale 1ns/1ps
module pnd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/pnd_sync.sv
`timescale 1ns/1ps
module pnd_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_async;
      hold_q <= meta_q;
    end
  end

  assign q_sync = hold_q;
endmodule

// File: rtl/pnd_subnet.sv
`timescale 1ns/1ps
module pnd_subnet
  import pnd_pkg::*;
#(
  parameter int NPLACE = 4,
  parameter int JOIN   = 2,
  parameter int NOUT   = 2,
  parameter logic [NPLACE*NOUT-1:0] MAP = '0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [NPLACE-1:0] x,
  input  logic [PHW-1:0]    peer_ph,
  output logic [PHW-1:0]    ph_g,
  output logic [NOUT-1:0]   y
);
  localparam int CW = (NPLACE > 2) ? $clog2(NPLACE) : 1;
  localparam logic [CW-1:0] JOIN_CODE = CW'(JOIN);

  function automatic logic [CW-1:0] ring_next(input logic [CW-1:0] p);
    return (p == CW'(NPLACE - 1)) ? '0 : p + CW'(1);
  endfunction

  logic           srst_n;
  logic [PHW-1:0] peer_s;

  pnd_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .srst_n(srst_n));
  pnd_sync #(.W(PHW)) u_peer (.clk(clk), .srst_n(srst_n), .d_async(peer_ph), .q_sync(peer_s));

  logic [CW-1:0]  place_q, place_d;
  logic [PHW-1:0] ph_q, ph_d;
  logic [PHW-1:0] ph_bin, peer_bin;

  assign ph_bin   = from_gray(ph_q);
  assign peer_bin = from_gray(peer_s);

  // Named events for the assertions
  logic at_join, join_fire, fire_any, arrive, ph_step;
  logic [NPLACE-1:0] cand;

  assign at_join   = (place_q == JOIN_CODE);
  assign join_fire = at_join & x[JOIN] & join_allowed(ph_bin, peer_bin);

  for (genvar k = 0; k < NPLACE; k++) begin : g_tr
    if (k == JOIN) begin : g_shared
      assign cand[k] = join_fire;
    end else begin : g_local
      assign cand[k] = (place_q == CW'(k)) & x[k];
    end
  end

  assign fire_any = |cand;
  assign place_d  = fire_any ? ring_next(place_q) : place_q;
  assign arrive   = fire_any & (ring_next(place_q) == JOIN_CODE);
  assign ph_step  = arrive | join_fire;
  assign ph_d     = ph_step ? to_gray(ph_bin + PHW'(1)) : ph_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      place_q <= '0;
      ph_q    <= '0;
    end else begin
      place_q <= place_d;
      ph_q    <= ph_d;
    end
  end

  assign ph_g = ph_q;

  always_comb begin
    y = '0;
    for (int k = 0; k < NPLACE; k++)
      if (place_q == CW'(k)) y = MAP[k*NOUT +: NOUT];
  end

  AST_RESET_HOME: assert property (@(posedge clk) !srst_n |=> (place_q == '0 && ph_q == '0)); // R1
  AST_RING_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    fire_any |=> place_q == ring_next($past(place_q))); // R3
  AST_HOLD_PLACE: assert property (@(posedge clk) disable iff (!srst_n)
    !fire_any |=> $stable(place_q)); // R4
  AST_JOIN_PARITY: assert property (@(posedge clk) disable iff (!srst_n)
    at_join == ph_bin[0]); // R10
  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(ph_q ^ $past(ph_q)) <= 1); // R10
endmodule

// File: rtl/pnd_dual_ctrl.sv
`timescale 1ns/1ps
module pnd_dual_ctrl
  import pnd_pkg::*;
#(
  parameter int NPLACE = 4,
  parameter int JOIN   = 2,
  parameter int NOUT   = 2,
  parameter logic [NPLACE*NOUT-1:0] MAP_A = 8'b10_11_01_00,
  parameter logic [NPLACE*NOUT-1:0] MAP_B = 8'b01_11_10_00
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic [NPLACE-1:0] x_a,
  input  logic [NPLACE-1:0] x_b,
  output logic [NOUT-1:0]   y_a,
  output logic [NOUT-1:0]   y_b
);
  logic [1:0]             clk_v;
  logic [1:0][NPLACE-1:0] x_v;
  logic [1:0][PHW-1:0]    ph_v;
  logic [1:0][NOUT-1:0]   y_v;

  assign clk_v = {clk_b, clk_a};
  assign x_v   = {x_b, x_a};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    pnd_subnet #(
      .NPLACE(NPLACE), .JOIN(JOIN), .NOUT(NOUT),
      .MAP((g == 0) ? MAP_A : MAP_B)
    ) u_lane (
      .clk    (clk_v[g]),
      .arst_n (rst_n),
      .x      (x_v[g]),
      .peer_ph(ph_v[1-g]),
      .ph_g   (ph_v[g]),
      .y      (y_v[g])
    );
  end

  assign y_a = y_v[0];
  assign y_b = y_v[1];
endmodule

// File: tb/pnd_dual_ctrl_test.sv
`timescale 1ns/1ps
module pnd_dual_ctrl_test;
  logic       clk_a = 0, clk_b = 0, clk_b_en = 1, rst_n = 0;
  logic [3:0] x_a = '0, x_b = '0;
  logic [1:0] y_a, y_b;

  pnd_dual_ctrl uut (.clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
                     .x_a(x_a), .x_b(x_b), .y_a(y_a), .y_b(y_b));

  always #2 clk_a = ~clk_a;                  // 250 MHz
  always #3.3 if (clk_b_en) clk_b = ~clk_b;  // unrelated period

  int n_chk = 0, n_err = 0;
  int pa = 0, pb = 0, ra = 0, rb = 0;
  bit finished = 0;
  logic [7:0] lfsr = 8'hA5;

  // R2 maps: lane A 00,01,11,10 ; lane B 00,10,11,01
  function automatic logic [1:0] word_a(input int p);
    return (p == 0) ? 2'b00 : (p == 1) ? 2'b01 : (p == 2) ? 2'b11 : 2'b10;
  endfunction
  function automatic logic [1:0] word_b(input int p);
    return (p == 0) ? 2'b00 : (p == 1) ? 2'b10 : (p == 2) ? 2'b11 : 2'b01;
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_both(input string tag);
    chk({tag, " lane A"}, y_a, word_a(pa));
    chk({tag, " lane B"}, y_b, word_b(pb));
  endtask

  task automatic drive(input bit side, input logic [3:0] v);
    if (side) x_b = v; else x_a = v;
  endtask

  task automatic step(input bit side);
    int cur  = side ? pb : pa;
    int mine = side ? rb : ra;
    int oth  = side ? ra : rb;
    int op   = side ? pa : pb;
    bit ready = ((op == 2) && (oth == mine)) || (oth == mine + 1);
    string tag;
    // other guard bits only (R4; at the join with a ready partner also R5)
    drive(side, 4'hF & ~(4'b1 << cur));
    #120;
    chk_both((cur == 2 && ready) ? "R5 own guard low" : "R4 foreign guards");
    drive(side, 4'b1 << cur);
    #120;
    if (cur != 2) begin
      tag = "R3 ring step";
      if (side) pb = (pb + 1) % 4; else pa = (pa + 1) % 4;
    end else if (ready) begin
      tag = (op == 2 && oth == mine) ? "R5 joint fire" : "R7 late side";
      if (side) begin pb = 3; rb++; end else begin pa = 3; ra++; end
    end else begin
      tag = (mine > oth) ? "R8 lapped wait" : "R6 lone wait";
    end
    chk_both(tag);
    drive(side, 4'b0);
    #40;
  endtask

  initial begin
    #600us;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    if (!finished) $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #11;
    chk("R1 in reset lane A", y_a, 2'b00);
    chk("R1 in reset lane B", y_b, 2'b00);
    #40 rst_n = 1;
    #61;
    chk_both("R1 after release");

    // R9: lane B frozen while its clock is stopped
    clk_b_en = 0;
    x_b = 4'b0001;
    step(0);
    #200;
    chk("R9 frozen lane B", y_b, word_b(0));
    chk("R9 lane A kept moving", y_a, word_a(pa));
    clk_b_en = 1;
    #120;
    pb = 1;
    chk("R9 resumed lane B", y_b, word_b(pb));
    x_b = 4'b0;
    #41;

    for (int i = 0; i < 160; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0]);
    end

    // R1: asynchronous reset with no edge needed
    clk_b_en = 0;
    #1 rst_n = 0;
    #1;
    pa = 0; pb = 0;
    chk_both("R1 async assert");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule